// File: doc/BRIEF.md
# Bus Ownership and Backoff Controller

This block sits between a processor's internal access path and a shared external address/data/control bus. It accepts one internal access at a time into a single-entry slot and runs it on the bus as a one-cycle address phase followed by a data phase. The data phase ends when the bus returns `bus_ready`. During the address phase it emits a 5-bit cycle code: one strobe bit and four type bits that separate program accesses from event accesses and give the port width. Floating the bus is modelled by `bus_oe`. While `bus_oe` is low, the address, data, write and code outputs sit at their idle values.

Two external agents can take the bus. A hold request is granted only at an access boundary, never while `lock` is high, and also while reset is asserted. A backoff input takes the bus on the next edge from any owning state. It aborts the access in flight, and the same access is replayed from its address phase after backoff falls. Backoff wins over hold. If both are present, the abort happens first, hold is granted after backoff falls, and the replay waits until hold is released. `breq` and `bstall` tell an outside arbiter whether an access is pending and whether the core is stuck waiting on it.

The controller has five states:
- IDLE: bus owned, no strobe.
- ADDR: address phase with strobe.
- DATA: waits for ready.
- BOFF: bus floated while backoff is high.
- HOLD: bus floated and granted. HOLD is also the reset state.

Transitions:
- IDLE→BOFF on backoff.
- IDLE→HOLD on a grantable hold.
- IDLE→ADDR when an access is pending.
- ADDR→BOFF on backoff, otherwise ADDR→DATA.
- DATA→BOFF on backoff.
- DATA→HOLD on ready with a grantable hold.
- DATA→IDLE on ready.
- BOFF→IDLE when backoff falls.
- HOLD→IDLE when hold falls.

Top module: `busown_ctrl`

## Requirements
- R1: A hold request arriving during an access is not acknowledged until the data phase completes with `bus_ready`. In the cycle after completion, `hold_ack` is 1 and `bus_oe` is 0.
- R2: When `hold_req` falls in HOLD, `hold_ack` is 0 in that same cycle, and `bus_oe` is 1 from the next cycle.
- R3: `hold_ack` is never 1 while `lock` is 1, and a hold request made while `lock` is 1 does not move the block into HOLD.
- R4: While `rst_n` is 0, `hold_ack` equals `hold_req && !lock`, `bus_oe` is 0 and `breq` is 0. Reset leaves the block in HOLD, so a hold still requested at reset release stays granted.
- R5: When `backoff` is 1 at a clock edge in IDLE, ADDR or DATA, `bus_oe` is 0 from that edge on, and no `resp_valid` is given for the aborted access.
- R6: After backoff falls (one IDLE cycle, then ADDR), the aborted access is reissued with the same address, write data, write flag and code. Each completed access shows exactly one address strobe more than the number of times it was aborted.
- R7: `breq` is 1 from the edge that accepts a request (`req_valid && req_ready`) until the edge that completes it. `req_ready` is `!breq` outside reset. No accepted access is lost or completed twice.
- R8: `bstall` is 1 exactly when `breq` and `core_wait` are both 1.
- R9: In the address phase `bus_code` = {0, 0, event, width}, with width 00 for 8-bit, 01 for 16-bit and 10 for 32-bit; request width 11 is sent as 10. In every other cycle `bus_code` is 10000.
- R10: An access accepted at edge t gives ADDR after edge t+1 and DATA after edge t+2. `resp_valid` is 1 with `resp_rdata = bus_rdata` in the DATA cycle where `bus_ready` is 1 and `backoff` is 0. In every other cycle `resp_rdata` is 0.
- R11: If backoff and hold are both present during an access, the access is aborted first. Hold is granted after backoff falls, and the replay starts only after hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal access request |
| req_ready | output | 1 | Slot free, request accepted this edge |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write |
| req_event | input | 1 | 1 = event-initiated access |
| req_width | input | 2 | Port width select (00/01/10, 11 = 32-bit) |
| core_wait | input | 1 | Core is blocked on the pending access |
| resp_valid | output | 1 | Access completed this cycle |
| resp_rdata | output | DATA_W | Read data of the completed access |
| bus_oe | output | 1 | Bus outputs driven (0 = floated) |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_write | output | 1 | Bus write flag |
| bus_code | output | 5 | Strobe bit and cycle type |
| bus_ready | input | 1 | Data phase complete |
| bus_rdata | input | DATA_W | Bus read data |
| hold_req | input | 1 | External hold request |
| hold_ack | output | 1 | Hold granted |
| lock | input | 1 | Locked sequence, hold refused |
| backoff | input | 1 | Force bus release and abort |
| breq | output | 1 | Access pending |
| bstall | output | 1 | Core stalled on pending access |

## Verification
A wrong state shows at the ports within one cycle. A stuck or misrouted state changes `bus_oe`, the strobe bit of `bus_code` or `hold_ack` on the very next edge. A backoff that fails to keep the aborted access surfaces at the replay: a changed `bus_addr` or `bus_code` in the next address phase, or a strobe count that does not match the abort count when the response arrives. A slot bookkeeping error shows as `breq` or `req_ready` disagreeing with the accepted and completed counts on the cycle after the faulty edge.

// File: rtl/busown_pkg.sv
package busown_pkg;
    localparam int TYPE_W = 4;
    localparam int CODE_W = TYPE_W + 1;
    localparam logic [CODE_W-1:0] IDLE_CODE = {1'b1, {TYPE_W{1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_BOFF,
        ST_HOLD
    } bus_st_e;

    typedef enum logic [1:0] {
        PW_8  = 2'b00,
        PW_16 = 2'b01,
        PW_32 = 2'b10
    } port_w_e;
endpackage

// File: rtl/busown_cycenc.sv
module busown_cycenc
    import busown_pkg::*;
(
    input  logic              addr_strobe,
    input  logic              is_event,
    input  logic [1:0]        width_sel,
    output logic [CODE_W-1:0] code
);
    port_w_e pw;

    always_comb begin
        pw = (width_sel == 2'b11) ? PW_32 : port_w_e'(width_sel);
        if (addr_strobe)
            code = {1'b0, 1'b0, is_event, pw};
        else
            code = IDLE_CODE;
    end
endmodule

// File: rtl/busown_reqslot.sv
module busown_reqslot #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_write,
    input  logic              in_event,
    input  logic [1:0]        in_width,
    output logic              valid_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              write_o,
    output logic              event_o,
    output logic [1:0]        width_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            wdata_o <= '0;
            write_o <= 1'b0;
            event_o <= 1'b0;
            width_o <= 2'b00;
        end else if (load) begin
            valid_o <= 1'b1;
            addr_o  <= in_addr;
            wdata_o <= in_wdata;
            write_o <= in_write;
            event_o <= in_event;
            width_o <= in_width;
        end else if (clear) begin
            valid_o <= 1'b0;
        end
    end

    // R6: a held access keeps its contents across aborts until completion
    p_slot_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !clear) |=> ($stable(addr_o) && $stable(wdata_o) &&
                                 $stable(write_o) && $stable(event_o) && $stable(width_o)));

    // R7: the single slot is never overwritten while occupied
    p_single_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid_o);
endmodule

// File: rtl/busown_fsm.sv
module busown_fsm
    import busown_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_valid,
    input  logic hold_req,
    input  logic lock,
    input  logic backoff,
    input  logic bus_ready,
    output logic own_bus,
    output logic addr_phase,
    output logic data_phase,
    output logic xfer_done,
    output logic hold_ack
);
    bus_st_e st, st_nx;
    logic    grant_ok;

    assign grant_ok = hold_req && !lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_HOLD;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (backoff)         st_nx = ST_BOFF;
                else if (grant_ok)   st_nx = ST_HOLD;
                else if (pend_valid) st_nx = ST_ADDR;
            end
            ST_ADDR: st_nx = backoff ? ST_BOFF : ST_DATA;
            ST_DATA: begin
                if (backoff)        st_nx = ST_BOFF;
                else if (bus_ready) st_nx = grant_ok ? ST_HOLD : ST_IDLE;
            end
            ST_BOFF: if (!backoff)  st_nx = ST_IDLE;
            ST_HOLD: if (!hold_req) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        own_bus    = 1'b0;
        addr_phase = 1'b0;
        data_phase = 1'b0;
        xfer_done  = 1'b0;
        hold_ack   = 1'b0;
        if (!rst_n) begin
            hold_ack = grant_ok;
        end else begin
            unique case (st)
                ST_IDLE: own_bus = 1'b1;
                ST_ADDR: begin
                    own_bus    = 1'b1;
                    addr_phase = 1'b1;
                end
                ST_DATA: begin
                    own_bus    = 1'b1;
                    data_phase = 1'b1;
                    xfer_done  = bus_ready && !backoff;
                end
                ST_BOFF: ;
                ST_HOLD: hold_ack = grant_ok;
                default: ;
            endcase
        end
    end

    // R1: no grant while a data phase is still waiting
    p_hold_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && !bus_ready) |=> !hold_ack);

    // R2: leaving hold gives the bus back on the next cycle
    p_hold_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !hold_req) |=> own_bus);

    // R3: a locked sequence never lets the block enter hold
    p_no_hold_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_HOLD && lock) |=> (st != ST_HOLD));

    // R5: backoff floats the bus on the next edge
    p_boff_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (backoff && st != ST_HOLD) |=> !own_bus);

    // R11: backoff wins over hold during an access
    p_boff_over_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (backoff && hold_req && (st == ST_ADDR || st == ST_DATA)) |=> !hold_ack);
endmodule

// File: rtl/busown_ctrl.sv
module busown_ctrl
    import busown_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_event,
    input  logic [1:0]        req_width,
    input  logic              core_wait,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_write,
    output logic [4:0]        bus_code,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              hold_req,
    output logic              hold_ack,
    input  logic              lock,
    input  logic              backoff,
    output logic              breq,
    output logic              bstall
);
    logic              slot_v, slot_wr, slot_ev;
    logic [ADDR_W-1:0] slot_addr;
    logic [DATA_W-1:0] slot_wd;
    logic [1:0]        slot_w;
    logic              own_bus, addr_phase, data_phase, xfer_done, drive;
    logic [CODE_W-1:0] code_w;

    assign req_ready = rst_n && !slot_v;

    busown_reqslot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (req_valid && req_ready),
        .clear    (xfer_done),
        .in_addr  (req_addr),
        .in_wdata (req_wdata),
        .in_write (req_write),
        .in_event (req_event),
        .in_width (req_width),
        .valid_o  (slot_v),
        .addr_o   (slot_addr),
        .wdata_o  (slot_wd),
        .write_o  (slot_wr),
        .event_o  (slot_ev),
        .width_o  (slot_w)
    );

    busown_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_valid (slot_v),
        .hold_req   (hold_req),
        .lock       (lock),
        .backoff    (backoff),
        .bus_ready  (bus_ready),
        .own_bus    (own_bus),
        .addr_phase (addr_phase),
        .data_phase (data_phase),
        .xfer_done  (xfer_done),
        .hold_ack   (hold_ack)
    );

    busown_cycenc u_enc (
        .addr_strobe (addr_phase),
        .is_event    (slot_ev),
        .width_sel   (slot_w),
        .code        (code_w)
    );

    assign drive      = addr_phase || data_phase;
    assign bus_oe     = own_bus;
    assign bus_addr   = drive ? slot_addr : '0;
    assign bus_wdata  = drive ? slot_wd : '0;
    assign bus_write  = drive && slot_wr;
    assign bus_code   = code_w;
    assign resp_valid = xfer_done;
    assign resp_rdata = xfer_done ? bus_rdata : '0;
    assign breq       = slot_v;
    assign bstall     = slot_v && core_wait;

    // R7: an accepted request shows as pending on the next cycle
    p_accept_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> breq);

    // R8: stall is only reported with a pending access
    p_stall_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bstall |-> breq);

    // R9: a strobe only appears on an owned bus
    p_strobe_owned_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_code[4] |-> bus_oe);

    // R10: a completion always belongs to a pending access
    p_resp_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> breq);
endmodule

// File: tb/busown_ctrl_tb.sv
module busown_ctrl_tb_top;
    localparam int CLK_PER = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int M_IDLE = 0, M_ADDR = 1, M_DATA = 2, M_BOFF = 3, M_HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, req_event = 0, core_wait = 0;
    logic [1:0] req_width = 0;
    logic [AW-1:0] req_addr = 0;
    logic [DW-1:0] req_wdata = 0, bus_rdata = 0;
    logic bus_ready = 0, hold_req = 0, lock = 0, backoff = 0;
    logic req_ready, resp_valid, bus_oe, bus_write, hold_ack, breq, bstall;
    logic [DW-1:0] resp_rdata, bus_wdata;
    logic [AW-1:0] bus_addr;
    logic [4:0] bus_code;

    always #(CLK_PER/2) clk = ~clk;

    busown_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .req_event(req_event), .req_width(req_width), .core_wait(core_wait),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .bus_oe(bus_oe),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_write(bus_write),
        .bus_code(bus_code), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .hold_req(hold_req), .hold_ack(hold_ack), .lock(lock), .backoff(backoff),
        .breq(breq), .bstall(bstall)
    );

    int vectors = 0, fails = 0;
    bit finished = 0;
    int m_st = M_HOLD;
    logic m_pv = 0, m_wr = 0, m_ev = 0;
    logic [1:0] m_w = 0;
    logic [AW-1:0] m_addr = 0;
    logic [DW-1:0] m_wd = 0;
    int m_abort = 0, obs_strobes = 0, accepted = 0, completed = 0;
    logic s_ack, s_oe, s_resp;
    logic [4:0] s_code;
    logic [AW-1:0] s_addr;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] exp_code(input logic ev, input logic [1:0] w);
        return {2'b00, ev, (w == 2'b11) ? 2'b10 : w};
    endfunction

    task automatic cyc(input logic rv, hr, lk, bo, rdy, cw);
        logic e_oe, e_ack, e_strb, e_drv, e_resp, e_rdy;
        logic [4:0] e_code;
        string ack_tag;
        @(negedge clk);
        req_valid = rv; hold_req = hr; lock = lk; backoff = bo; bus_ready = rdy; core_wait = cw;
        req_addr = $urandom; req_wdata = $urandom; req_write = 1'($urandom % 2);
        req_event = 1'($urandom % 2); req_width = 2'($urandom % 4); bus_rdata = $urandom;
        if (!rst_n) begin m_st = M_HOLD; m_pv = 0; m_abort = 0; obs_strobes = 0; end
        #1;
        e_oe   = rst_n && (m_st == M_IDLE || m_st == M_ADDR || m_st == M_DATA);
        e_ack  = !rst_n ? (hr && !lk) : (m_st == M_HOLD && hr && !lk);
        e_strb = rst_n && m_st == M_ADDR;
        e_drv  = rst_n && (m_st == M_ADDR || m_st == M_DATA);
        e_code = e_strb ? exp_code(m_ev, m_w) : 5'b10000;
        e_resp = rst_n && m_st == M_DATA && rdy && !bo;
        e_rdy  = rst_n && !m_pv;
        if (!rst_n) ack_tag = "R4";
        else if (m_st == M_HOLD && !hr) ack_tag = "R2";
        else if (lk) ack_tag = "R3";
        else if (m_abort > 0) ack_tag = "R11";
        else ack_tag = "R1";
        chk(ack_tag, hold_ack, e_ack);
        chk(rst_n ? "R5" : "R4", bus_oe, e_oe);
        chk("R9", bus_code, e_code);
        chk("R6", bus_addr, e_drv ? m_addr : '0);
        chk("R6", bus_wdata, e_drv ? m_wd : '0);
        chk("R6", bus_write, e_drv && m_wr);
        chk(rst_n ? "R7" : "R4", breq, m_pv);
        chk("R7", req_ready, e_rdy);
        chk("R8", bstall, m_pv && cw);
        chk("R10", resp_valid, e_resp);
        chk("R10", resp_rdata, e_resp ? bus_rdata : '0);
        s_ack = hold_ack; s_oe = bus_oe; s_code = bus_code; s_resp = resp_valid; s_addr = bus_addr;
        if (rst_n) begin
            if (!bus_code[4]) obs_strobes++;
            if (e_resp) begin
                // R6: exactly one strobe per attempt, replayed once per abort
                chk("R6", obs_strobes, m_abort + 1);
                completed++; m_pv = 0; m_abort = 0; obs_strobes = 0;
            end
            if (rv && e_rdy) begin
                accepted++; m_pv = 1; m_addr = req_addr; m_wd = req_wdata;
                m_wr = req_write; m_ev = req_event; m_w = req_width;
            end
            case (m_st)
                M_IDLE: if (bo) m_st = M_BOFF;
                        else if (hr && !lk) m_st = M_HOLD;
                        else if (m_pv && !(rv && e_rdy)) m_st = M_ADDR;
                M_ADDR: if (bo) begin m_st = M_BOFF; m_abort++; end else m_st = M_DATA;
                M_DATA: if (bo) begin m_st = M_BOFF; m_abort++; end
                        else if (rdy) m_st = (hr && !lk) ? M_HOLD : M_IDLE;
                M_BOFF: if (!bo) m_st = M_IDLE;
                default: if (!hr) m_st = M_IDLE;
            endcase
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic bo_r, hr_r, lk_r;
        logic [AW-1:0] keep_addr;
        void'($urandom(32'd2024));
        // R4: reset grants hold, refused under lock
        repeat (3) cyc(0, 1, 0, 0, 0, 0);
        chk("R4", s_ack, 1); chk("R4", s_oe, 0);
        cyc(0, 1, 1, 0, 0, 0); chk("R4", s_ack, 0);
        rst_n = 1'b1;
        cyc(0, 1, 0, 0, 0, 0); chk("R4", s_ack, 1);
        // R2: drop hold, bus returns next cycle
        cyc(0, 0, 0, 0, 0, 0); chk("R2", s_ack, 0);
        cyc(0, 0, 0, 0, 0, 0); chk("R2", s_oe, 1);
        // R3: lock blocks a hold request
        repeat (3) begin cyc(0, 1, 1, 0, 0, 0); chk("R3", s_ack, 0); end
        cyc(0, 1, 0, 0, 0, 0); chk("R3", s_ack, 0);
        cyc(0, 1, 0, 0, 0, 0); chk("R3", s_ack, 1);
        cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
        // R1 / R10: hold arriving mid-access waits for completion
        cyc(1, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 1); chk("R10", s_code[4], 0);
        cyc(0, 1, 0, 0, 0, 1); chk("R1", s_ack, 0);
        cyc(0, 1, 0, 0, 1, 1); chk("R10", s_resp, 1); chk("R1", s_ack, 0);
        cyc(0, 1, 0, 0, 0, 0); chk("R1", s_ack, 1); chk("R1", s_oe, 0);
        cyc(0, 0, 0, 0, 0, 0);
        // R11 / R5 / R6: backoff with hold, then replay
        cyc(1, 0, 0, 0, 0, 0); keep_addr = m_addr;
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0, 0); chk("R5", s_resp, 0);
        cyc(0, 1, 0, 1, 0, 0); chk("R5", s_oe, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0); chk("R11", s_ack, 1);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0); chk("R6", s_addr, keep_addr); chk("R11", s_code[4], 0);
        cyc(0, 0, 0, 0, 1, 0); chk("R6", s_resp, 1);
        // constrained random mix
        bo_r = 0; hr_r = 0; lk_r = 0;
        for (int i = 0; i < 4000; i++) begin
            bo_r = bo_r ? ($urandom % 3 != 0) : ($urandom % 12 == 0);
            hr_r = hr_r ? ($urandom % 6 != 0) : ($urandom % 20 == 0);
            lk_r = lk_r ? ($urandom % 5 != 0) : ($urandom % 15 == 0);
            cyc(1'($urandom % 3 != 0), hr_r, lk_r, bo_r, 1'($urandom % 2), 1'($urandom % 2));
        end
        // R7: nothing dropped or duplicated
        chk("R7", completed + int'(m_pv), accepted);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule